// File: doc/BRIEF.md
# Selective Replay Dependence Tracker

This block sits beside an out-of-order scheduler that wakes up consumers of loads before those loads know whether they hit in the cache. For every tracked instruction it keeps a small bit matrix. Each column stands for one issue slot of the memory pipeline. Each row stands for one cycle of age between the schedule stage and the stage where a cache miss becomes known. A set bit means that the instruction depends, directly or through any chain of producers, on the load that issued in that slot that many cycles ago.

When the scheduler issues an instruction, it names the tracker entries of its producers. The tracker ORs the producers' broadcast matrices into the new entry. A load also adds its own slot bit to the top row of the matrix that it offers to its consumers. All matrices age by one row per cycle. When the miss stage raises a kill flag for a slot, every entry whose oldest row carries that slot is invalidated in that same cycle. This reaches every level of dependence at once and leaves independent work untouched. Bits that age out of the oldest row without a kill are dropped, because those dependences are confirmed.

Top module: `sel_replay_tracker`

## Requirements
- R1: While reset is high and after it is released, all entries hold no dependence, so no kill pattern raises any invalidate; a reset in mid-run discards the dependences recorded before it.
- R2: A load issued in slot s during cycle c places bit s in the top row of its broadcast matrix. A consumer issued during c+1 or c+2 (ROWS=3) is invalidated in cycle c+ROWS when kill bit s is high.
- R3: An issued instruction's matrix is the bitwise OR of the broadcast matrices of all its valid producers. A load that consumes another load carries both dependences.
- R4: Every matrix moves down one row per cycle. A kill that matches a bit that has not yet reached the oldest row has no effect.
- R5: Kill bit k matches only column k. A kill on the other slot leaves a dependent entry valid.
- R6: An entry with no dependence on the killed slot's oldest row is never invalidated.
- R7: All dependents of a killed load, including indirect ones several producer levels away, are invalidated in the single cycle in which the kill is raised.
- R8: A bit that leaves the oldest row without a matching kill is discarded, so a later kill on that slot does not touch the entry.
- R9: An invalidated entry is cleared. A kill raised later on another slot it had depended on does not invalidate it again.
- R10: An instruction issued in the same cycle as a kill, whose merged producer matrix holds the killed slot in the oldest row, is invalidated in that cycle and records no dependence.
- R11: A load is not invalidated by the kill raised for its own slot; only its consumers are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | An instruction is issued this cycle |
| iss_idx | input | IDX_W | Tracker entry of the issued instruction |
| iss_src_vld | input | SRCS | Per producer operand: producer is tracked |
| iss_src_idx | input | SRCS*IDX_W | Producer entries, operand 0 in the low bits |
| iss_is_load | input | 1 | The issued instruction is a load |
| iss_slot | input | SLOT_W | Memory issue slot of the issued load |
| kill | input | SLOTS | Bit k: the load of slot k in the miss stage missed |
| inv | output | ENTRIES | Bit e: entry e is cancelled this cycle |

## Verification
The stimulus runs direct consumers and two-level consumers of one load, so that it can separate single-level tracking from true transitive closure. It raises kills one cycle too early, on the wrong slot, and one cycle too late, so that it can separate the row position and the column from the aging. Consumers of two loads in different slots, killed one slot at a time, show whether the merge is a true OR and whether a cleared entry stays cleared. An issue that lands in the kill cycle and a reset in mid-run cover the edges of the timing window.

// File: rtl/srt_pkg.sv
package srt_pkg;

  localparam int DEF_ENTRIES = 8;
  localparam int DEF_SLOTS   = 2;
  localparam int DEF_ROWS    = 3;
  localparam int DEF_SRCS    = 2;

  typedef enum logic [1:0] {
    ACT_AGE,
    ACT_FILL,
    ACT_DROP
  } act_e;

endpackage

// File: rtl/srt_merge.sv
module srt_merge #(
  parameter int ENTRIES = 8,
  parameter int SRCS    = 2,
  parameter int MW      = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0][MW-1:0] bcast_all,
  input  logic [SRCS-1:0]            src_vld,
  input  logic [SRCS*IDX_W-1:0]      src_idx,
  output logic [MW-1:0]              merged
);

  logic [SRCS-1:0][MW-1:0] picked;

  for (genvar i = 0; i < SRCS; i++) begin : g_src
    logic [IDX_W-1:0] sel;
    assign sel       = src_idx[i*IDX_W +: IDX_W];
    assign picked[i] = src_vld[i] ? bcast_all[sel] : '0;
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < SRCS; i++) merged = merged | picked[i];
  end

endmodule

// File: rtl/srt_entry.sv
module srt_entry
  import srt_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int SLOTS = 2,
  localparam int MW   = ROWS * SLOTS,
  localparam int OLD_LO = (ROWS - 1) * SLOTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [MW-1:0]    wr_mat,
  input  logic             wr_load,
  input  logic [SLOTS-1:0] wr_slot_oh,
  input  logic [SLOTS-1:0] kill,
  output logic [MW-1:0]    bcast_o,
  output logic             inv_o
);

  logic          live;
  logic [MW-1:0] dep;
  logic [MW-1:0] brd;
  logic          hit_old;
  logic          hit_new;
  logic [MW-1:0] own;
  act_e          act;

  function automatic logic [MW-1:0] age(input logic [MW-1:0] m);
    return m << SLOTS;
  endfunction

  assign hit_old = live && |(dep[MW-1:OLD_LO] & kill);
  assign hit_new = wr_en && |(wr_mat[MW-1:OLD_LO] & kill);
  assign own     = wr_load ? {{(MW-SLOTS){1'b0}}, wr_slot_oh} : '0;

  always_comb begin
    if (wr_en)        act = hit_new ? ACT_DROP : ACT_FILL;
    else if (hit_old) act = ACT_DROP;
    else              act = ACT_AGE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= 1'b0;
      dep  <= '0;
      brd  <= '0;
    end else begin
      case (act)
        ACT_FILL: begin
          live <= 1'b1;
          dep  <= age(wr_mat);
          brd  <= age(wr_mat) | own;
        end
        ACT_DROP: begin
          live <= 1'b0;
          dep  <= '0;
          brd  <= '0;
        end
        default: begin
          dep <= age(dep);
          brd <= age(brd);
        end
      endcase
    end
  end

  assign inv_o   = hit_old | hit_new;
  assign bcast_o = brd;

  // R6: nothing recorded and nothing arriving means no cancel
  a_r6_quiet_without_dependence: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && dep == '0) |-> !inv_o);

  // R9: a cancelled entry keeps no dependence afterwards
  a_r9_cleared_after_cancel: assert property (@(posedge clk) disable iff (rst)
    (inv_o && !wr_en) |=> (dep == '0 && brd == '0));

  // R4/R8: without a new issue the dependence set can only shrink
  a_r4_bits_never_grow: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($countones(dep) <= $past($countones(dep))));

  // R2: an issued load exposes its own slot in the top row
  a_r2_own_slot_on_top: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_load && !hit_new) |=>
      ((brd[SLOTS-1:0] & $past(wr_slot_oh)) == $past(wr_slot_oh)));

endmodule

// File: rtl/sel_replay_tracker.sv
module sel_replay_tracker
  import srt_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int SLOTS   = DEF_SLOTS,
  parameter int ROWS    = DEF_ROWS,
  parameter int SRCS    = DEF_SRCS,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int MW     = ROWS * SLOTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  iss_vld,
  input  logic [IDX_W-1:0]      iss_idx,
  input  logic [SRCS-1:0]       iss_src_vld,
  input  logic [SRCS*IDX_W-1:0] iss_src_idx,
  input  logic                  iss_is_load,
  input  logic [SLOT_W-1:0]     iss_slot,
  input  logic [SLOTS-1:0]      kill,
  output logic [ENTRIES-1:0]    inv
);

  logic [ENTRIES-1:0][MW-1:0] bcast;
  logic [MW-1:0]              merged;
  logic [SLOTS-1:0]           slot_oh;

  always_comb begin
    slot_oh = '0;
    for (int k = 0; k < SLOTS; k++)
      if (iss_slot == SLOT_W'(k)) slot_oh[k] = 1'b1;
  end

  srt_merge #(
    .ENTRIES (ENTRIES),
    .SRCS    (SRCS),
    .MW      (MW)
  ) u_merge (
    .bcast_all (bcast),
    .src_vld   (iss_src_vld),
    .src_idx   (iss_src_idx),
    .merged    (merged)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wr_here;
    assign wr_here = iss_vld && (iss_idx == IDX_W'(e));

    srt_entry #(
      .ROWS  (ROWS),
      .SLOTS (SLOTS)
    ) u_ent (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_here),
      .wr_mat     (merged),
      .wr_load    (iss_is_load),
      .wr_slot_oh (slot_oh),
      .kill       (kill),
      .bcast_o    (bcast[e]),
      .inv_o      (inv[e])
    );
  end

  // R6/R7: a cancel only happens when some slot is being killed
  a_r6_no_kill_no_cancel: assert property (@(posedge clk) disable iff (rst)
    (kill == '0) |-> (inv == '0));

  // R3: every valid producer's broadcast is contained in the merged matrix
  for (genvar i = 0; i < SRCS; i++) begin : g_chk
    logic [IDX_W-1:0] psel;
    assign psel = iss_src_idx[i*IDX_W +: IDX_W];
    a_r3_merge_covers_parent: assert property (@(posedge clk) disable iff (rst)
      (iss_vld && iss_src_vld[i]) |-> ((merged & bcast[psel]) == bcast[psel]));
  end

endmodule

// File: tb/test_sel_replay_tracker.sv
module test_sel_replay_tracker;

  typedef struct packed {
    logic       vld;
    logic [2:0] idx;
    logic [1:0] sv;
    logic [2:0] s0;
    logic [2:0] s1;
    logic       ld;
    logic       slot;
    logic [1:0] kill;
    logic [7:0] exp;
  } vec_t;

  function automatic vec_t v(input logic vld, input logic [2:0] idx, input logic [1:0] sv,
                             input logic [2:0] s0, input logic [2:0] s1, input logic ld,
                             input logic slot, input logic [1:0] kill, input logic [7:0] exp);
    vec_t r;
    r.vld = vld; r.idx = idx; r.sv = sv; r.s0 = s0; r.s1 = s1;
    r.ld = ld; r.slot = slot; r.kill = kill; r.exp = exp;
    return r;
  endfunction

  localparam int N = 23;
  localparam vec_t TBL [N] = '{
    v(1,0,0,0,0,1,0,2'b00,8'h00),  // load e0 slot0
    v(1,1,1,0,0,0,0,2'b00,8'h00),  // e1 <- e0
    v(1,2,1,1,0,0,0,2'b00,8'h00),  // e2 <- e1 (two levels)
    v(1,4,1,0,0,0,0,2'b01,8'h16),  // R2 R7 R10 R11: kill slot0, e1 e2 and issuing e4
    v(0,0,0,0,0,0,0,2'b01,8'h00),  // R8 R9: repeated kill, nothing left
    v(1,5,0,0,0,1,1,2'b00,8'h00),  // load e5 slot1
    v(1,6,3,5,3,0,0,2'b00,8'h00),  // e6 <- e5 and untracked e3
    v(0,0,0,0,0,0,0,2'b10,8'h00),  // R4: kill one cycle early
    v(0,0,0,0,0,0,0,2'b01,8'h00),  // R5: kill on the other slot
    v(0,0,0,0,0,0,0,2'b10,8'h00),  // R8: kill one cycle late
    v(1,0,0,0,0,1,0,2'b00,8'h00),  // load e0 slot0
    v(1,3,1,0,0,1,1,2'b00,8'h00),  // load e3 slot1 <- e0
    v(1,7,1,3,0,0,0,2'b00,8'h00),  // e7 <- e3
    v(0,0,0,0,0,0,0,2'b01,8'h88),  // R3 R7: kill slot0 cancels e3 and e7
    v(1,1,0,0,0,1,1,2'b00,8'h00),  // load e1 slot1
    v(1,2,1,1,0,0,0,2'b00,8'h00),  // e2 <- e1
    v(1,4,0,0,0,0,0,2'b00,8'h00),  // e4 independent
    v(0,0,0,0,0,0,0,2'b10,8'h04),  // R6 R11: only e2 cancelled
    v(1,5,0,0,0,1,0,2'b00,8'h00),  // load e5 slot0
    v(1,6,0,0,0,1,1,2'b00,8'h00),  // load e6 slot1
    v(1,7,3,5,6,0,0,2'b00,8'h00),  // e7 <- e5 and e6
    v(0,0,0,0,0,0,0,2'b01,8'h80),  // R3: kill slot0 cancels e7
    v(0,0,0,0,0,0,0,2'b10,8'h00)   // R9: e7 already cleared
  };

  localparam string TAG [N] = '{
    "R2", "R2", "R7", "R2 R7 R10 R11", "R8 R9", "R3", "R3", "R4", "R5", "R8",
    "R3", "R3", "R3", "R3 R7", "R6", "R6", "R6", "R6 R11", "R3", "R3", "R3", "R3",
    "R9"
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       iss_vld;
  logic [2:0] iss_idx;
  logic [1:0] iss_src_vld;
  logic [5:0] iss_src_idx;
  logic       iss_is_load;
  logic       iss_slot;
  logic [1:0] kill;
  logic [7:0] inv;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sel_replay_tracker i_sel_replay_tracker (
    .clk         (clk),
    .rst         (rst),
    .iss_vld     (iss_vld),
    .iss_idx     (iss_idx),
    .iss_src_vld (iss_src_vld),
    .iss_src_idx (iss_src_idx),
    .iss_is_load (iss_is_load),
    .iss_slot    (iss_slot),
    .kill        (kill),
    .inv         (inv)
  );

  task automatic drive(input vec_t t);
    iss_vld     = t.vld;
    iss_idx     = t.idx;
    iss_src_vld = t.sv;
    iss_src_idx = {t.s1, t.s0};
    iss_is_load = t.ld;
    iss_slot    = t.slot;
    kill        = t.kill;
  endtask

  task automatic check(input string req, input logic [7:0] expv);
    tests++;
    if (inv !== expv) begin
      fails++;
      $display("FAIL %s: inv=%h expected %h", req, inv, expv);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(v(0,0,0,0,0,0,0,2'b00,8'h00));
    repeat (3) @(posedge clk);
    @(negedge clk);
    kill = 2'b11;
    #1 check("R1 during reset", 8'h00);
    rst = 1'b0;
    @(negedge clk);
    #1 check("R1 after reset", 8'h00);

    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      #1;
      tests++;
      if (inv !== TBL[k].exp) begin
        fails++;
        $display("FAIL vec %0d (%s): inv=%h expected %h", k, TAG[k], inv, TBL[k].exp);
      end
    end

    // R1: a reset in mid-run erases the recorded chain
    @(negedge clk); drive(v(1,0,0,0,0,1,0,2'b00,8'h00));
    @(negedge clk); drive(v(1,1,1,0,0,0,0,2'b00,8'h00));
    @(negedge clk); drive(v(0,0,0,0,0,0,0,2'b00,8'h00)); rst = 1'b1;
    @(negedge clk); rst = 1'b0; kill = 2'b01;
    #1 check("R1 mid-run reset", 8'h00);

    // R2: one-cycle gap consumer still caught, producer load untouched (R11)
    @(negedge clk); drive(v(1,3,0,0,0,1,1,2'b00,8'h00));
    @(negedge clk); drive(v(0,0,0,0,0,0,0,2'b00,8'h00));
    @(negedge clk); drive(v(1,5,1,3,0,0,0,2'b00,8'h00));
    @(negedge clk); drive(v(0,0,0,0,0,0,0,2'b10,8'h00));
    #1 check("R2 R11 gap consumer", 8'h20);

    @(negedge clk); drive(v(0,0,0,0,0,0,0,2'b00,8'h00));
    #1 check("R9 idle after cancel", 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule